// File: doc/BRIEF.md
# Sixteen-Channel DAC Serial Command Front End

This block is the digital front end that sits in front of a 16-channel digital-to-analog converter. A host drives it over a four-wire serial link (serial clock, active-low chip select, data in, data out). Each transaction carries a command byte and a 16-bit payload. The block decodes the command and updates its register state: a staged (input) and an active (DAC) code per channel, a 3-bit output span selector, and the dither controls. Every active channel code and every dither and span setting is brought out on parallel output ports for the analog section to use.

The serial pins are resampled in the system clock domain through two-flop synchronisers. A receive state machine frames each transaction and has four states. `RX_IDLE` waits for chip select to fall and goes to `RX_SHIFT`. `RX_SHIFT` counts serial clock rising edges and shifts in data. From there, chip select rising after exactly 24 bits goes to `RX_COMMIT`, chip select rising at any other count goes back to `RX_IDLE`, and a 25th rising edge goes to `RX_OVERRUN`. `RX_OVERRUN` holds until chip select rises and then returns to `RX_IDLE`. `RX_COMMIT` is a single-cycle state in which the frame is decoded and applied, and it always returns to `RX_IDLE`.

Readback takes two frames. The first frame names a channel. The next frame shifts that channel's active code out on the data-out pin, while the host sends a no-op on data in. The `CODE_BITS` parameter builds a reduced-resolution variant whose codes stay left-aligned in the 16-bit word.

Top module: `dac_cmd_frontend`

## Requirements
- R1: A frame takes effect only when chip select rises after exactly 24 serial clock rising edges. A frame with 23 bits or 25 bits changes no register.
- R2: Command byte 0x1n (n = low nibble) stores the payload in channel n's staged register and leaves every active code unchanged.
- R3: Command byte 0x2n stores the payload directly in channel n's active code and leaves all other channels unchanged.
- R4: Command byte 0x30 copies the staged register into the active code for every channel i whose payload bit i is 1. Channels whose bit is 0 keep their code.
- R5: Command byte 0x60 writes the payload into the active code of all 16 channels in one frame.
- R6: Command byte 0x70 restores every register to its reset value, but only when the payload is 0x1234. Any other payload changes nothing.
- R7: After reset, all codes, staged values, the dither invert, source and scale words, and the span are zero. The dither power-down word is 0xFFFF (bit i = 1 means channel i's dither is off), and data out is 0.
- R8: After a frame with command byte 0x8n, the following frame shifts out, MSB first on data out, the byte 0x00 followed by channel n's active code. Data out is all zeros when no readback is pending.
- R9: Command byte 0x51 loads the 16-bit dither power-down word. Command byte 0xB0 loads the 16-bit dither invert word (bit i belongs to channel i).
- R10: The 32-bit dither source and scale words use 2 bits per channel (channel i at bits 2i+1:2i; scale codes 0..3 mean x1, x0.75, x0.5, x0.25). Command bytes 0x90 and 0xA0 write the low and high 16 bits of the source word. Command bytes 0xC0 and 0xD0 write the low and high 16 bits of the scale word.
- R11: Command byte 0x40 loads payload bits 2:0 into the span selector.
- R12: Command bytes outside the set above (for example 0x01, 0x31, 0x50, 0x61, 0xE0, 0xF5) change no register.
- R13: With CODE_BITS = 12, every code write stores the payload with its low 4 bits forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data in, sampled on serial clock rise |
| miso | output | 1 | Serial data out, advances on serial clock fall |
| dac_code | output | 256 | Active code of channel i at bits 16i+15:16i |
| dither_pd | output | 16 | Dither power-down per channel (1 = off) |
| dither_inv | output | 16 | Dither invert per channel |
| dither_src | output | 32 | Dither source, 2 bits per channel |
| dither_scl | output | 32 | Dither scale, 2 bits per channel |
| span_code | output | 3 | Output span selector |

## Verification
The bench sends frames that are one bit short and one bit long, each carrying a direct code write. A receiver that commits on a count threshold instead of an exact count would let these frames alter a channel. The reset key is tested one value below the valid key, and a loose comparison would then clear the whole register file. The bench requests readback of every channel in turn and then runs a no-op frame with nothing pending; a design that kept the request alive or latched the wrong channel would shift out stale data. Masked loads use sparse and complementary masks to expose a swapped bit order. A second instance built with 12-bit codes runs the same traffic, so any leak of the low nibble shows up on its outputs.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
    localparam int NCH     = 16;
    localparam int CH_W    = $clog2(NCH);
    localparam int CMD_W   = 8;
    localparam int DATA_W  = 16;
    localparam int FRAME_W = CMD_W + DATA_W;
    localparam int SPAN_W  = 3;
    localparam logic [DATA_W-1:0] RESET_KEY = 16'h1234;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_OVERRUN,
        RX_COMMIT
    } rx_state_t;

    typedef struct packed {
        logic [NCH-1:0] wr_in;
        logic [NCH-1:0] wr_dac;
        logic [NCH-1:0] load;
        logic           bcast;
        logic           full_rst;
        logic           span;
        logic           dpwr;
        logic           inv;
        logic           src_lo;
        logic           src_hi;
        logic           scl_lo;
        logic           scl_hi;
        logic           rb_req;
    } dec_t;
endpackage

// File: rtl/dac_fe_spi_rx.sv
module dac_fe_spi_rx
    import dac_fe_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk,
    input  logic          cs_n,
    input  logic          mosi,
    input  logic [FW-1:0] tx_word,
    output logic          miso,
    output logic          frame_commit,
    output logic [FW-1:0] frame_word
);
    localparam int CNT_W = $clog2(FW + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);

    logic [2:0] sclk_s, cs_s;
    logic [1:0] mosi_s;
    logic sclk_rise, sclk_fall, cs_fall, cs_rise;
    rx_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [FW-1:0] rx_q, tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_s <= '0;
            cs_s   <= '1;
            mosi_s <= '0;
        end else begin
            sclk_s <= {sclk_s[1:0], sclk};
            cs_s   <= {cs_s[1:0], cs_n};
            mosi_s <= {mosi_s[0], mosi};
        end
    end

    assign sclk_rise = sclk_s[1] & ~sclk_s[2];
    assign sclk_fall = ~sclk_s[1] & sclk_s[2];
    assign cs_fall   = ~cs_s[1] & cs_s[2];
    assign cs_rise   = cs_s[1] & ~cs_s[2];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:    if (cs_fall) state_d = RX_SHIFT;
            RX_SHIFT: begin
                if (cs_rise)
                    state_d = (cnt_q == CNT_FULL) ? RX_COMMIT : RX_IDLE;
                else if (sclk_rise && cnt_q == CNT_FULL)
                    state_d = RX_OVERRUN;
            end
            RX_OVERRUN: if (cs_rise) state_d = RX_IDLE;
            RX_COMMIT:  state_d = RX_IDLE;
            default:    state_d = RX_IDLE;
        endcase
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rx_q  <= '0;
            tx_q  <= '0;
        end else if (state_q == RX_IDLE) begin
            if (cs_fall) begin
                cnt_q <= '0;
                tx_q  <= tx_word;
            end
        end else if (state_q == RX_SHIFT && !cs_rise) begin
            if (sclk_rise && cnt_q != CNT_FULL) begin
                rx_q  <= {rx_q[FW-2:0], mosi_s[1]};
                cnt_q <= cnt_q + 1'b1;
            end
            if (sclk_fall)
                tx_q <= {tx_q[FW-2:0], 1'b0};
        end
    end

    // outputs
    always_comb begin
        frame_commit = (state_q == RX_COMMIT);
        frame_word   = rx_q;
        miso         = (state_q == RX_SHIFT) & tx_q[FW-1];
    end
endmodule

// File: rtl/dac_fe_decode.sv
module dac_fe_decode
    import dac_fe_pkg::*;
(
    input  logic               frame_commit,
    input  logic [FRAME_W-1:0] frame_word,
    output dec_t               dec
);
    logic [CMD_W-1:0]  cmd;
    logic [DATA_W-1:0] data;
    logic [3:0]        hi, lo;

    assign cmd  = frame_word[FRAME_W-1 -: CMD_W];
    assign data = frame_word[DATA_W-1:0];
    assign hi   = cmd[7:4];
    assign lo   = cmd[3:0];

    always_comb begin
        dec = '0;
        if (frame_commit) begin
            case (hi)
                4'h1: dec.wr_in[lo[CH_W-1:0]]  = 1'b1;
                4'h2: dec.wr_dac[lo[CH_W-1:0]] = 1'b1;
                4'h3: if (lo == 4'h0) dec.load = data[NCH-1:0];
                4'h4: dec.span   = (lo == 4'h0);
                4'h5: dec.dpwr   = (lo == 4'h1);
                4'h6: dec.bcast  = (lo == 4'h0);
                4'h7: dec.full_rst = (lo == 4'h0) && (data == RESET_KEY);
                4'h8: dec.rb_req = 1'b1;
                4'h9: dec.src_lo = (lo == 4'h0);
                4'hA: dec.src_hi = (lo == 4'h0);
                4'hB: dec.inv    = (lo == 4'h0);
                4'hC: dec.scl_lo = (lo == 4'h0);
                4'hD: dec.scl_hi = (lo == 4'h0);
                default: dec = '0;
            endcase
        end
    end
endmodule

// File: rtl/dac_fe_chan.sv
module dac_fe_chan
    import dac_fe_pkg::*;
#(
    parameter int CODE_BITS = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_in,
    input  logic              wr_dac,
    input  logic              load,
    input  logic              bcast,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dac_q
);
    localparam int PAD = DATA_W - CODE_BITS;
    localparam logic [DATA_W-1:0] KEEP = DATA_W'({DATA_W{1'b1}} << PAD);

    logic [DATA_W-1:0] in_q;
    logic [DATA_W-1:0] wcode;

    assign wcode = wdata & KEEP;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q  <= '0;
            dac_q <= '0;
        end else if (clr) begin
            in_q  <= '0;
            dac_q <= '0;
        end else begin
            if (wr_in) in_q <= wcode;
            if (wr_dac || bcast) dac_q <= wcode;
            else if (load)       dac_q <= in_q;
        end
    end
endmodule

// File: rtl/dac_fe_cfg.sv
module dac_fe_cfg
    import dac_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_span,
    input  logic              wr_pwr,
    input  logic              wr_inv,
    input  logic              wr_src_lo,
    input  logic              wr_src_hi,
    input  logic              wr_scl_lo,
    input  logic              wr_scl_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [NCH-1:0]    pd_q,
    output logic [NCH-1:0]    inv_q,
    output logic [2*NCH-1:0]  src_q,
    output logic [2*NCH-1:0]  scl_q,
    output logic [SPAN_W-1:0] span_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_q <= '1; inv_q <= '0; src_q <= '0; scl_q <= '0; span_q <= '0;
        end else if (clr) begin
            pd_q <= '1; inv_q <= '0; src_q <= '0; scl_q <= '0; span_q <= '0;
        end else begin
            if (wr_span)   span_q <= wdata[SPAN_W-1:0];
            if (wr_pwr)    pd_q   <= wdata[NCH-1:0];
            if (wr_inv)    inv_q  <= wdata[NCH-1:0];
            if (wr_src_lo) src_q[DATA_W-1:0]       <= wdata;
            if (wr_src_hi) src_q[2*NCH-1:DATA_W]   <= wdata;
            if (wr_scl_lo) scl_q[DATA_W-1:0]       <= wdata;
            if (wr_scl_hi) scl_q[2*NCH-1:DATA_W]   <= wdata;
        end
    end
endmodule

// File: rtl/dac_cmd_frontend.sv
module dac_cmd_frontend
    import dac_fe_pkg::*;
#(
    parameter int CODE_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  cs_n,
    input  logic                  mosi,
    output logic                  miso,
    output logic [NCH*DATA_W-1:0] dac_code,
    output logic [NCH-1:0]        dither_pd,
    output logic [NCH-1:0]        dither_inv,
    output logic [2*NCH-1:0]      dither_src,
    output logic [2*NCH-1:0]      dither_scl,
    output logic [SPAN_W-1:0]     span_code
);
    logic               frame_commit;
    logic [FRAME_W-1:0] frame_word;
    logic [FRAME_W-1:0] tx_word;
    dec_t               dec;
    logic [NCH-1:0]     wr_in_vec, wr_dac_vec;
    logic               full_rst;
    logic               rb_pend_q;
    logic [CH_W-1:0]    rb_sel_q;
    logic [DATA_W-1:0]  dac_arr [NCH];

    dac_fe_spi_rx #(.FW(FRAME_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .tx_word(tx_word), .miso(miso),
        .frame_commit(frame_commit), .frame_word(frame_word)
    );

    dac_fe_decode u_dec (
        .frame_commit(frame_commit), .frame_word(frame_word), .dec(dec)
    );

    assign wr_in_vec  = dec.wr_in;
    assign wr_dac_vec = dec.wr_dac;
    assign full_rst   = dec.full_rst;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        dac_fe_chan #(.CODE_BITS(CODE_BITS)) u_chan (
            .clk(clk), .rst_n(rst_n), .clr(full_rst),
            .wr_in(wr_in_vec[ch]), .wr_dac(wr_dac_vec[ch]),
            .load(dec.load[ch]), .bcast(dec.bcast),
            .wdata(frame_word[DATA_W-1:0]), .dac_q(dac_arr[ch])
        );
        assign dac_code[ch*DATA_W +: DATA_W] = dac_arr[ch];
    end

    dac_fe_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .clr(full_rst),
        .wr_span(dec.span), .wr_pwr(dec.dpwr), .wr_inv(dec.inv),
        .wr_src_lo(dec.src_lo), .wr_src_hi(dec.src_hi),
        .wr_scl_lo(dec.scl_lo), .wr_scl_hi(dec.scl_hi),
        .wdata(frame_word[DATA_W-1:0]),
        .pd_q(dither_pd), .inv_q(dither_inv), .src_q(dither_src),
        .scl_q(dither_scl), .span_q(span_code)
    );

    // readback request: valid for exactly the next committed frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_pend_q <= 1'b0;
            rb_sel_q  <= '0;
        end else if (full_rst) begin
            rb_pend_q <= 1'b0;
            rb_sel_q  <= '0;
        end else if (frame_commit) begin
            rb_pend_q <= dec.rb_req;
            rb_sel_q  <= frame_word[DATA_W +: CH_W];
        end
    end

    assign tx_word = rb_pend_q ? {{CMD_W{1'b0}}, dac_arr[rb_sel_q]} : '0;
endmodule

// File: rtl/dac_fe_chk.sv
module dac_fe_chk
    import dac_fe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frame_commit,
    input logic [NCH-1:0]    wr_in_vec,
    input logic [NCH-1:0]    wr_dac_vec,
    input logic              full_rst,
    input logic [NCH-1:0]    dither_pd,
    input logic [SPAN_W-1:0] span_code
);
    // R1
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_commit |=> !frame_commit);
    // R2
    wr_in_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_in_vec));
    // R3
    wr_dac_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_dac_vec));
    // R6
    reset_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_rst |-> frame_commit);
    // R9
    pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_commit |=> $stable(dither_pd));
    // R11
    span_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_commit |=> $stable(span_code));
endmodule

bind dac_cmd_frontend dac_fe_chk u_chk (
    .clk(clk), .rst_n(rst_n), .frame_commit(frame_commit),
    .wr_in_vec(wr_in_vec), .wr_dac_vec(wr_dac_vec), .full_rst(full_rst),
    .dither_pd(dither_pd), .span_code(span_code)
);

// File: tb/tb_dac_cmd_frontend.sv
`timescale 1ns/1ps
module tb_dac_cmd_frontend;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, miso12;
    logic [255:0] dac_code, dac_code12;
    logic [15:0] dither_pd, dither_inv, pd12, inv12;
    logic [31:0] dither_src, dither_scl, src12, scl12;
    logic [2:0]  span_code, span12;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [15:0] m_in [16];
    logic [15:0] m_dac [16];
    logic [15:0] m_pd, m_inv;
    logic [31:0] m_src, m_scl;
    logic [2:0]  m_span;
    bit          m_pend;
    int          m_sel;
    logic [23:0] last_rx, exp_rx;

    always #2.5 clk = ~clk;

    dac_cmd_frontend dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .dac_code(dac_code), .dither_pd(dither_pd),
        .dither_inv(dither_inv), .dither_src(dither_src),
        .dither_scl(dither_scl), .span_code(span_code)
    );

    dac_cmd_frontend #(.CODE_BITS(12)) dut12 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso12), .dac_code(dac_code12), .dither_pd(pd12),
        .dither_inv(inv12), .dither_src(src12),
        .dither_scl(scl12), .span_code(span12)
    );

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin m_in[i] = '0; m_dac[i] = '0; end
        m_pd = 16'hFFFF; m_inv = '0; m_src = '0; m_scl = '0; m_span = '0;
        m_pend = 0; m_sel = 0;
    endtask

    task automatic model_apply(input logic [7:0] c, input logic [15:0] d);
        int lo;
        bit rb;
        lo = int'(c[3:0]);
        rb = (c[7:4] == 4'h8);
        case (c[7:4])
            4'h1: m_in[lo] = d;
            4'h2: m_dac[lo] = d;
            4'h3: if (lo == 0) for (int i = 0; i < 16; i++) if (d[i]) m_dac[i] = m_in[i];
            4'h4: if (lo == 0) m_span = d[2:0];
            4'h5: if (lo == 1) m_pd = d;
            4'h6: if (lo == 0) for (int i = 0; i < 16; i++) m_dac[i] = d;
            4'h9: if (lo == 0) m_src[15:0] = d;
            4'hA: if (lo == 0) m_src[31:16] = d;
            4'hB: if (lo == 0) m_inv = d;
            4'hC: if (lo == 0) m_scl[15:0] = d;
            4'hD: if (lo == 0) m_scl[31:16] = d;
            default: ;
        endcase
        m_pend = rb;
        m_sel  = lo;
        if (c == 8'h70 && d == 16'h1234) model_reset();
    endtask

    task automatic send_bits(input logic [7:0] c, input logic [15:0] d, input int nbits);
        logic [31:0] w;
        w = {c, d, 8'h00};
        last_rx = '0;
        cs_n = 1'b0;
        wclk(6);
        for (int i = 0; i < nbits; i++) begin
            mosi = w[31-i];
            wclk(5);
            if (i < 24) last_rx[23-i] = miso;
            sclk = 1'b1;
            wclk(5);
            sclk = 1'b0;
        end
        wclk(3);
        cs_n = 1'b1;
        mosi = 1'b0;
        wclk(10);
    endtask

    task automatic xfer(input logic [7:0] c, input logic [15:0] d);
        exp_rx = m_pend ? {8'h00, m_dac[m_sel]} : 24'h0;
        send_bits(c, d, 24);
        model_apply(c, d);
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 16; i++) begin
            chk({tag, " code"}, 32'(dac_code[i*16 +: 16]), 32'(m_dac[i]));
            chk({tag, " code12 R13"}, 32'(dac_code12[i*16 +: 16]), 32'(m_dac[i] & 16'hFFF0));
        end
        chk({tag, " pd"},   32'(dither_pd),  32'(m_pd));
        chk({tag, " inv"},  32'(dither_inv), 32'(m_inv));
        chk({tag, " src"},  dither_src, m_src);
        chk({tag, " scl"},  dither_scl, m_scl);
        chk({tag, " span"}, 32'(span_code), 32'(m_span));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        // R7 reset state
        check_all("R7");
        chk("R7 miso", 32'(miso), 32'h0);

        // R2 staged writes on every channel, active codes untouched
        for (int ch = 0; ch < 16; ch++)
            xfer(8'h10 | 8'(ch), 16'((ch * 16'h1357) ^ 16'hA5C3));
        check_all("R2");

        // R4 masked loads
        xfer(8'h30, 16'h00F0);  check_all("R4 mask 00F0");
        xfer(8'h30, 16'h8001);  check_all("R4 mask 8001");
        xfer(8'h30, 16'hFF0F);  check_all("R4 mask FF0F");

        // R3 direct writes sweep
        for (int ch = 0; ch < 16; ch++) begin
            xfer(8'h20 | 8'(ch), 16'(16'hFFFF - ch * 16'h0F0F));
            chk("R3 chan", 32'(dac_code[ch*16 +: 16]), 32'(m_dac[ch]));
        end
        check_all("R3");

        // R8 readback of every channel
        for (int ch = 0; ch < 16; ch++) begin
            xfer(8'h80 | 8'(ch), 16'h0000);
            xfer(8'h00, 16'h0000);
            chk("R8 readback", 32'(last_rx), 32'(exp_rx));
        end
        xfer(8'h00, 16'h0000);
        chk("R8 no pending", 32'(last_rx), 32'h0);

        // R9 / R10 / R11 configuration words
        xfer(8'h51, 16'h5A3C); check_all("R9 pwr");
        xfer(8'hB0, 16'hC00F); check_all("R9 inv");
        xfer(8'h90, 16'h1B2D); check_all("R10 src lo");
        xfer(8'hA0, 16'hE4F0); check_all("R10 src hi");
        xfer(8'hC0, 16'h3210); check_all("R10 scl lo");
        xfer(8'hD0, 16'hFEDC); check_all("R10 scl hi");
        for (int s = 0; s < 8; s++) begin
            xfer(8'h40, 16'hFFF8 | 16'(s));
            check_all("R11 span");
        end

        // R12 unrecognised commands
        xfer(8'h01, 16'hFFFF); xfer(8'h31, 16'hFFFF); xfer(8'h50, 16'h0000);
        xfer(8'h61, 16'h1111); xfer(8'hE0, 16'h2222); xfer(8'hF5, 16'h3333);
        xfer(8'h41, 16'h0001); xfer(8'h71, 16'h1234);
        check_all("R12");

        // R5 broadcast
        xfer(8'h60, 16'h9E37); check_all("R5");

        // R1 short and long frames are discarded
        send_bits(8'h23, 16'h0BAD, 23); check_all("R1 short");
        send_bits(8'h24, 16'h0BAD, 25); check_all("R1 long");
        xfer(8'h25, 16'h7777);          check_all("R1 exact");

        // R6 wrong key, then right key
        xfer(8'h70, 16'h1233); check_all("R6 bad key");
        xfer(8'h80, 16'h0000);
        xfer(8'h70, 16'h1234); check_all("R6 reset");
        xfer(8'h00, 16'h0000);
        chk("R6 pending cleared", 32'(last_rx), 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule